// File: doc/BRIEF.md
# Conversion Setup Latch and Input Decoder

This block is the control front end of a dual converter, where each converter sits behind its own multiplexer. It watches an active-low conversion strobe. At every high-to-low transition of that strobe it captures a 3-bit channel address, an input-mode select (single-ended or differential) and a span select (narrow or wide). It then decodes the setting that governs the current conversion into input indices, a ground-return flag, a pseudo-differential flag, the active span and the output number format. The same indices go to every converter.

A setting captured at one strobe fall does not apply to the conversion started by that fall. It sits in a pending stage and only becomes active at the following fall. Two reserved address codes are refused: an error flag is raised and the pending stage is left alone. The strobe is a plain control pin that is synchronous to `clk`, so there is no data stream and no back-pressure at the block's edge.

Top module: `conv_cfg_latch`

## Requirements
- R1: After reset the active setting is address 0, single-ended, narrow span. So pos_idx is 1 for every converter, neg_idx is 0, neg_gnd is 1, pseudo_diff is 0, wide_act is 0, twos_comp is 0 and cfg_err is 0.
- R2: The inputs addr_in, se_in and wide_in are captured only in a clock cycle where cs_n is sampled low after being sampled high. Changes at any other time leave every output unchanged.
- R3: A setting captured at one cs_n fall becomes the active setting, visible on the outputs, one clock after the next cs_n fall.
- R4: With se_in=1 (single-ended), address a in 0..5 gives pos_idx=a+1, neg_idx=0 and neg_gnd=1.
- R5: With se_in=0 (differential), addresses 0/1 give pos_idx 1 and neg_idx 2, addresses 2/3 give 3 and 4, and addresses 4/5 give 5 and 6, with neg_gnd=0.
- R6: In differential mode, address bit 0 = 1 means pseudo-differential and drives pseudo_diff=1. Address bit 0 = 0 means fully differential. In single-ended mode pseudo_diff is 0.
- R7: wide_act equals the wide_in value captured with the active setting (0 means a span of zero to the reference, 1 means twice the reference).
- R8: twos_comp is 1 (twos complement) for fully differential inputs on either span and for single-ended inputs on the wide span. It is 0 (straight binary) for single-ended inputs on the narrow span and for pseudo-differential inputs on either span.
- R9: A fall that captures address 6 or 7 sets cfg_err from the next clock until the next fall, and leaves the pending stage unchanged. A fall with a valid address clears cfg_err.
- R10: All converters receive identical pos_idx and neg_idx values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low conversion strobe; its falls capture the inputs |
| addr_in | input | 3 | Channel address |
| se_in | input | 1 | 1 = single-ended, 0 = differential |
| wide_in | input | 1 | 1 = wide span, 0 = narrow span |
| pos_idx | output | NUM_CONV*3 | Positive input index per converter (1..6) |
| neg_idx | output | NUM_CONV*3 | Negative input index per converter (0 = ground) |
| neg_gnd | output | 1 | Negative side returns to ground |
| pseudo_diff | output | 1 | Active setting is pseudo-differential |
| wide_act | output | 1 | Active span is the wide one |
| twos_comp | output | 1 | Result coded in twos complement |
| cfg_err | output | 1 | Last captured address was reserved |

## Verification
The bench builds the block with its defaults: two converters, three input pairs and a 3-bit address. At these values all eight address codes are reachable in both input modes and on both spans, including the two reserved codes. The per-converter equality check therefore compares two real copies of the decode. Strobe pulses of several lengths, with the inputs scrambled while the strobe is low and while it is high, show that only the sampled fall matters. They also show that the pending and active stages advance one step per fall.

// File: rtl/conv_cfg_pkg.sv
package conv_cfg_pkg;
  localparam int ADDR_W    = 3;
  localparam int NUM_PAIRS = 3;
  localparam int NUM_IN    = 2 * NUM_PAIRS;
  localparam int IDX_W     = $clog2(NUM_IN + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              se;
    logic              wide;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{addr: '0, se: 1'b1, wide: 1'b0};
endpackage

// File: rtl/conv_cfg_capture.sv
module conv_cfg_capture
  import conv_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  cfg_t cfg_in,
  output logic fall,
  output cfg_t pend,
  output logic cfg_err
);
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(NUM_IN);

  logic cs_q;
  logic addr_ok;

  assign fall    = cs_q & ~cs_n;
  assign addr_ok = cfg_in.addr < ADDR_LIMIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      pend    <= CFG_RESET;
      cfg_err <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (fall) begin
        cfg_err <= ~addr_ok;
        if (addr_ok) pend <= cfg_in;
      end
    end
  end
endmodule

// File: rtl/conv_cfg_stage.sv
module conv_cfg_stage
  import conv_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  cfg_t pend,
  output cfg_t active
);
  always_ff @(posedge clk) begin
    if (!rst_n)       active <= CFG_RESET;
    else if (advance) active <= pend;
  end
endmodule

// File: rtl/conv_cfg_decode.sv
module conv_cfg_decode
  import conv_cfg_pkg::*;
#(
  parameter int NUM_CONV = 2
) (
  input  cfg_t                      active,
  output logic [NUM_CONV*IDX_W-1:0] pos_idx,
  output logic [NUM_CONV*IDX_W-1:0] neg_idx,
  output logic                      neg_gnd,
  output logic                      pseudo_diff,
  output logic                      wide_act,
  output logic                      twos_comp
);
  logic [IDX_W-1:0] pair_base;
  logic [IDX_W-1:0] pos_one;
  logic [IDX_W-1:0] neg_one;

  always_comb begin
    pair_base = IDX_W'({active.addr[ADDR_W-1:1], 1'b0});
    if (active.se) begin
      pos_one     = IDX_W'(active.addr) + IDX_W'(1);
      neg_one     = '0;
      neg_gnd     = 1'b1;
      pseudo_diff = 1'b0;
      twos_comp   = active.wide;
    end else begin
      pos_one     = pair_base + IDX_W'(1);
      neg_one     = pair_base + IDX_W'(2);
      neg_gnd     = 1'b0;
      pseudo_diff = active.addr[0];
      twos_comp   = ~active.addr[0];
    end
    wide_act = active.wide;
  end

  for (genvar c = 0; c < NUM_CONV; c++) begin : g_conv
    assign pos_idx[c*IDX_W +: IDX_W] = pos_one;
    assign neg_idx[c*IDX_W +: IDX_W] = neg_one;
  end
endmodule

// File: rtl/conv_cfg_latch.sv
module conv_cfg_latch
  import conv_cfg_pkg::*;
#(
  parameter int NUM_CONV = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic [ADDR_W-1:0]         addr_in,
  input  logic                      se_in,
  input  logic                      wide_in,
  output logic [NUM_CONV*IDX_W-1:0] pos_idx,
  output logic [NUM_CONV*IDX_W-1:0] neg_idx,
  output logic                      neg_gnd,
  output logic                      pseudo_diff,
  output logic                      wide_act,
  output logic                      twos_comp,
  output logic                      cfg_err
);
  cfg_t cfg_in;
  cfg_t pend;
  cfg_t active;
  logic fall;

  assign cfg_in = '{addr: addr_in, se: se_in, wide: wide_in};

  conv_cfg_capture u_capture (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_in(cfg_in),
    .fall(fall), .pend(pend), .cfg_err(cfg_err)
  );

  conv_cfg_stage u_stage (
    .clk(clk), .rst_n(rst_n), .advance(fall), .pend(pend), .active(active)
  );

  conv_cfg_decode #(.NUM_CONV(NUM_CONV)) u_decode (
    .active(active), .pos_idx(pos_idx), .neg_idx(neg_idx),
    .neg_gnd(neg_gnd), .pseudo_diff(pseudo_diff),
    .wide_act(wide_act), .twos_comp(twos_comp)
  );
endmodule

// File: rtl/conv_cfg_latch_chk.sv
module conv_cfg_latch_chk
  import conv_cfg_pkg::*;
#(
  parameter int NUM_CONV = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cs_n,
  input logic [ADDR_W-1:0]         addr_in,
  input logic [NUM_CONV*IDX_W-1:0] pos_idx,
  input logic [NUM_CONV*IDX_W-1:0] neg_idx,
  input logic                      neg_gnd,
  input logic                      pseudo_diff,
  input logic                      wide_act,
  input logic                      twos_comp,
  input logic                      cfg_err
);
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(NUM_IN);

  logic cs_d;
  always_ff @(posedge clk) begin
    if (!rst_n) cs_d <= 1'b1;
    else        cs_d <= cs_n;
  end

  a_r2_hold_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_d && !cs_n) |=> ($stable(pos_idx) && $stable(neg_idx) &&
                          $stable(twos_comp) && $stable(wide_act) && $stable(cfg_err)));

  a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && !cs_n && addr_in >= ADDR_LIMIT) |=> cfg_err);

  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && !cs_n && addr_in < ADDR_LIMIT) |=> !cfg_err);

  a_r8_pseudo_straight: assert property (@(posedge clk) disable iff (!rst_n)
    pseudo_diff |-> !twos_comp);

  a_r8_se_narrow_straight: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_gnd && !wide_act) |-> !twos_comp);

  a_r6_pseudo_only_diff: assert property (@(posedge clk) disable iff (!rst_n)
    neg_gnd |-> !pseudo_diff);

  a_r10_same_index: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_idx[IDX_W-1:0] == pos_idx[NUM_CONV*IDX_W-1 -: IDX_W]) &&
    (neg_idx[IDX_W-1:0] == neg_idx[NUM_CONV*IDX_W-1 -: IDX_W]));
endmodule

bind conv_cfg_latch conv_cfg_latch_chk #(.NUM_CONV(NUM_CONV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_in(addr_in),
  .pos_idx(pos_idx), .neg_idx(neg_idx), .neg_gnd(neg_gnd),
  .pseudo_diff(pseudo_diff), .wide_act(wide_act), .twos_comp(twos_comp),
  .cfg_err(cfg_err)
);

// File: tb/conv_cfg_latch_tb_top.sv
module conv_cfg_latch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCONV = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic [2:0] addr_in = 3'd0;
  logic se_in = 1'b0;
  logic wide_in = 1'b0;
  logic [NCONV*IW-1:0] pos_idx, neg_idx;
  logic neg_gnd, pseudo_diff, wide_act, twos_comp, cfg_err;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_cfg_latch #(.NUM_CONV(NCONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_in(addr_in),
    .se_in(se_in), .wide_in(wide_in), .pos_idx(pos_idx), .neg_idx(neg_idx),
    .neg_gnd(neg_gnd), .pseudo_diff(pseudo_diff), .wide_act(wide_act),
    .twos_comp(twos_comp), .cfg_err(cfg_err)
  );

  // reference model: pending and active settings as plain integers
  int m_cs = 1;
  int p_addr = 0, p_se = 1, p_wide = 0;
  int a_addr = 0, a_se = 1, a_wide = 0;
  int m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 1; p_addr = 0; p_se = 1; p_wide = 0;
      a_addr = 0; a_se = 1; a_wide = 0; m_err = 0;
    end else begin
      if (m_cs == 1 && cs_n == 1'b0) begin
        a_addr = p_addr; a_se = p_se; a_wide = p_wide;
        m_err = (addr_in >= 6) ? 1 : 0;
        if (addr_in < 6) begin
          p_addr = addr_in; p_se = se_in; p_wide = wide_in;
        end
      end
      m_cs = cs_n;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // full comparison against the model, every cycle
  task automatic compare_all();
    int e_pos, e_neg, e_gnd, e_ps, e_tc;
    if (a_se == 1) begin
      e_pos = a_addr + 1; e_neg = 0; e_gnd = 1; e_ps = 0;
      e_tc = a_wide;                           // R8 single-ended
    end else begin
      e_pos = (a_addr / 2) * 2 + 1; e_neg = e_pos + 1; e_gnd = 0;
      e_ps = a_addr % 2;                       // R6
      e_tc = (e_ps == 1) ? 0 : 1;              // R8 differential
    end
    for (int c = 0; c < NCONV; c++) begin
      chk("R4 R5 R10 pos_idx", int'(pos_idx[c*IW +: IW]), e_pos);
      chk("R4 R5 R10 neg_idx", int'(neg_idx[c*IW +: IW]), e_neg);
    end
    chk("R4 neg_gnd", int'(neg_gnd), e_gnd);
    chk("R6 pseudo_diff", int'(pseudo_diff), e_ps);
    chk("R7 wide_act", int'(wide_act), a_wide);
    chk("R8 twos_comp", int'(twos_comp), e_tc);
    chk("R9 cfg_err", int'(cfg_err), m_err);
  endtask

  always @(negedge clk) begin
    if (rst_n) compare_all();
  end

  // one strobe: set inputs, pull low, scramble while low, release, scramble
  task automatic frame(input int a, input int se, input int wd, input int low_n, input int high_n);
    @(negedge clk);
    addr_in = 3'(a); se_in = 1'(se); wide_in = 1'(wd); cs_n = 1'b0;
    for (int i = 0; i < low_n; i++) begin
      @(negedge clk);
      addr_in = 3'(7 - a); se_in = ~se_in; wide_in = ~wide_in;  // R2 scramble
    end
    cs_n = 1'b1;
    for (int i = 0; i < high_n; i++) begin
      @(negedge clk);
      addr_in = 3'(i); se_in = 1'(i % 2); wide_in = 1'((i / 2) % 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 pos_idx", int'(pos_idx[IW-1:0]), 1);
    chk("R1 neg_gnd", int'(neg_gnd), 1);
    chk("R1 twos_comp", int'(twos_comp), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);

    // R3 delay: first captured setting not yet active
    frame(3, 0, 1, 2, 2);
    #1;
    chk("R3 pos before next fall", int'(pos_idx[IW-1:0]), 1);
    frame(0, 1, 0, 3, 2);
    #1;
    chk("R3 pos after next fall", int'(pos_idx[IW-1:0]), 3);
    chk("R3 pseudo after next fall", int'(pseudo_diff), 1);

    // sweep every combination, including reserved codes
    for (int se = 0; se < 2; se++)
      for (int wd = 0; wd < 2; wd++)
        for (int a = 0; a < 8; a++)
          frame(a, se, wd, 1 + (a % 3), 1 + (a % 2));

    // R9 reserved capture keeps the pending stage
    frame(4, 0, 0, 1, 1);
    frame(7, 1, 1, 1, 1);
    #1;
    chk("R9 err raised", int'(cfg_err), 1);
    frame(1, 1, 0, 1, 1);
    #1;
    chk("R9 pending kept pos", int'(pos_idx[IW-1:0]), 5);
    chk("R9 pending kept neg", int'(neg_idx[IW-1:0]), 6);
    chk("R9 err cleared", int'(cfg_err), 0);

    // R2 long idle with changing inputs, no fall
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      addr_in = 3'(i); se_in = 1'(i % 2); wide_in = 1'(i % 3 == 0);
    end
    #1;
    chk("R2 idle keeps pos", int'(pos_idx[IW-1:0]), 5);

    frame(0, 1, 0, 1, 2);
    frame(0, 1, 0, 1, 2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule